// File: doc/BRIEF.md
# Memory Sweep Test Engine

This engine exercises a byte-wide RAM through a synchronous single-cycle port. For every byte it writes a generated value, reads the byte back and compares the result with the value it wrote. Pages of 256 bytes are visited from the highest page down to page 0, and offsets within a page run from 0xFF down to 0x00. The whole memory is swept `PASSES` times (256 by default). After the last pass the engine raises a completion flag and stops touching the memory.

The written value is the byte offset, inverted while an internal flip flag is 0, plus the current pass counter (mod 256). The flip flag starts at 0 and toggles after every page. It toggles once more at the end of each pass, so the final page of a pass leaves it unchanged. The pass counter starts at 0 and counts down once per pass, so its two's-complement negation equals the number of finished passes.

Every mismatch bumps an 8-bit error counter and sets a sticky flag. With stop-on-error enabled, the engine freezes after a mismatch until the resume input has been seen high and then low. An 8-bit display output shows either the error count or the finished-pass count.

Top module: `mem_sweep_test`

## Requirements
- R1: While reset is asserted, the error counter, pass counter, display and all three flags are 0, and the port presents a write to the top address (all ones).
- R2: Each byte gets one write cycle, then one read cycle to the same address, then one compare cycle. Bytes are visited with offset 0xFF down to 0x00 inside each page, and pages are visited from the highest down to page 0.
- R3: The write value is `(flip ? offset : ~offset) + pass_cnt` modulo 256.
- R4: The flip flag is 0 after reset and toggles after each page. At the end of each pass it toggles once more, so the last page of a pass leaves it unchanged.
- R5: The pass counter starts at 0 and decrements by one at the end of each pass. After `PASSES` passes, `done` is set and held, and no further memory access occurs.
- R6: Read data is taken from `mem_rdata` in the cycle after the read cycle. Each mismatch increments the error counter modulo 256 and sets the sticky `err_seen` flag.
- R7: With `stop_en` = 1, a mismatch sets `stopped` and halts all memory access. The engine continues only after `resume` has been sampled 1 and later sampled 0; `stopped` then clears.
- R8: With `stop_en` = 0, a mismatch is counted and the sweep continues without pause.
- R9: `disp` equals `err_cnt` when `disp_sel` = 0, and equals `-pass_cnt` (mod 256) when `disp_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_en | input | 1 | Pause after a mismatch when 1 |
| resume | input | 1 | Continue after a pause: high, then low |
| disp_sel | input | 1 | 0 = error count, 1 = finished passes |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid the cycle after mem_re |
| err_cnt | output | 8 | Mismatch count, wraps at 256 |
| pass_cnt | output | 8 | Down-counting pass counter |
| disp | output | 8 | Selected counter view |
| done | output | 1 | All passes finished |
| stopped | output | 1 | Paused after a mismatch |
| err_seen | output | 1 | At least one mismatch since reset |

## Verification
The assertions watch these properties on every cycle:
- write and read strobes are never active together;
- each write is followed by a read to the same address;
- the counters only step by one in their own direction;
- `done` and `err_seen` are sticky;
- the memory stays idle while stopped or finished.

Other behaviour can only be shown by the bench's scenarios. These cover the exact write values and the page-by-page flip pattern across passes, and the resume handshake that needs both a high and a low phase. They also cover the wrap of the error counter after a burst of 256 mismatches and the display view.

// File: rtl/mem_sweep_test.sv
module mem_sweep_test #(
  parameter int ADDR_W = 17,
  parameter int PASSES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_en,
  input  logic              resume,
  input  logic              disp_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        err_cnt,
  output logic [7:0]        pass_cnt,
  output logic [7:0]        disp,
  output logic              done,
  output logic              stopped,
  output logic              err_seen
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [7:0] FINAL_CNT = 8'((257 - PASSES) % 256);

  typedef enum logic [2:0] {S_WR, S_RD, S_CMP, S_WHI, S_WLO, S_FIN} state_t;
  state_t state;

  logic [PAGE_W-1:0] page;
  logic [7:0]        off;
  logic              flip;
  logic              miss, step;

  assign mem_addr  = {page, off};
  assign mem_we    = (state == S_WR);
  assign mem_re    = (state == S_RD);
  assign mem_wdata = (flip ? off : ~off) + pass_cnt;
  assign miss      = (state == S_CMP) && (mem_rdata != mem_wdata);
  assign step      = ((state == S_CMP) && !(miss && stop_en)) || ((state == S_WLO) && !resume);
  assign disp      = disp_sel ? 8'(-pass_cnt) : err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WR;
      page     <= '1;
      off      <= 8'hFF;
      flip     <= 1'b0;
      pass_cnt <= 8'h00;
      err_cnt  <= 8'h00;
      err_seen <= 1'b0;
      stopped  <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state)
        S_WR:  state <= S_RD;
        S_RD:  state <= S_CMP;
        S_CMP: if (miss) begin
                 err_cnt  <= err_cnt + 8'd1;
                 err_seen <= 1'b1;
                 if (stop_en) begin
                   stopped <= 1'b1;
                   state   <= S_WHI;
                 end
               end
        S_WHI: if (resume) state <= S_WLO;
        S_WLO: if (!resume) stopped <= 1'b0;
        default: state <= S_FIN;
      endcase
      if (step) begin
        state <= S_WR;
        off   <= off - 8'd1;
        if (off == 8'h00) begin
          page <= page - 1'b1;
          // page toggle plus end-of-pass toggle cancel on page 0
          if (page != '0) flip <= ~flip;
          else begin
            pass_cnt <= pass_cnt - 8'd1;
            if (pass_cnt == FINAL_CNT) begin
              done  <= 1'b1;
              state <= S_FIN;
            end
          end
        end
      end
    end
  end

  // R2
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  // R2
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_re && mem_addr == $past(mem_addr)));
  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_cnt) |-> err_cnt == $past(err_cnt) + 8'd1);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err_seen |=> err_seen);
  // R5
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_cnt) |-> pass_cnt == $past(pass_cnt) - 8'd1);
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !mem_we && !mem_re));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!mem_we && !mem_re));
  // R8
  no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_en && !stopped) |=> !$rose(stopped));
endmodule

// File: tb/sim_mem_sweep_test.sv
`timescale 1ns/1ps
module sim_mem_sweep_test;
  localparam int AW = 10;
  localparam int NP = 4;
  localparam int NW = NP * (1 << AW);

  logic clk = 1'b0;
  logic rst_n = 1'b0, stop_en = 1'b0, resume = 1'b0, disp_sel = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re, done, stopped, err_seen;
  logic [7:0] mem_wdata, mem_rdata, err_cnt, pass_cnt, disp;

  always #5 clk = ~clk;

  mem_sweep_test #(.ADDR_W(AW), .PASSES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .resume(resume), .disp_sel(disp_sel),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .err_cnt(err_cnt), .pass_cnt(pass_cnt), .disp(disp),
    .done(done), .stopped(stopped), .err_seen(err_seen));

  logic [7:0] ram [1 << AW];
  logic fault_on = 1'b0;
  logic [AW-1:0] f_lo = '0, f_hi = '0;
  logic [AW-1:0] log_a [NW];
  logic [7:0]    log_d [NW];
  int widx, order_bad;
  logic [AW-1:0] last_wa;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr] ^ {7'd0, fault_on && mem_addr >= f_lo && mem_addr <= f_hi};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= 0; order_bad <= 0;
    end else begin
      if (mem_we) begin
        if (widx < NW) begin log_a[widx] <= mem_addr; log_d[widx] <= mem_wdata; end
        widx <= widx + 1;
        last_wa <= mem_addr;
      end
      if (mem_re && mem_addr != last_wa) order_bad <= order_bad + 1;
    end
  end

  // {write ordinal, address, data}
  localparam logic [29:0] VEC [8] = '{
    {12'd0,    10'h3FF, 8'h00}, {12'd1,    10'h3FE, 8'h01},
    {12'd255,  10'h300, 8'hFF}, {12'd256,  10'h2FF, 8'hFF},
    {12'd257,  10'h2FE, 8'hFE}, {12'd1023, 10'h000, 8'h00},
    {12'd1025, 10'h3FE, 8'hFD}, {12'd3072, 10'h3FF, 8'hFC}};

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 counters", {err_cnt, pass_cnt, disp}, 0);
    chk("R1 flags", {done, stopped, err_seen}, 0);
    chk("R1 first access", {mem_we, mem_addr}, {1'b1, 10'h3FF});
    rst_n = 1'b1;

    // Run 1: clean memory
    while (!done) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R2 address", log_a[VEC[i][29:18]], VEC[i][17:8]);
      chk("R3 R4 data", log_d[VEC[i][29:18]], VEC[i][7:0]);
    end
    chk("R2 write count", widx, NW);
    chk("R2 read follows write", order_bad, 0);
    chk("R5 pass counter", pass_cnt, 8'hFC);
    chk("R6 no errors", {err_cnt, err_seen}, 0);
    w0 = widx;
    repeat (50) @(negedge clk);
    chk("R5 done held, idle", {done, mem_we, mem_re, 8'(widx - w0)}, {1'b1, 1'b0, 1'b0, 8'd0});
    disp_sel = 1'b1; #1;
    chk("R9 pass view", disp, 4);
    disp_sel = 1'b0; #1;
    chk("R9 error view", disp, 0);

    // Run 2: single bad byte, stop-on-error
    fault_on = 1'b1; f_lo = 10'h2F0; f_hi = 10'h2F0; stop_en = 1'b1;
    do_reset();
    while (!stopped) @(negedge clk);
    chk("R6 first mismatch", {err_cnt, err_seen}, {8'd1, 1'b1});
    w0 = widx;
    repeat (20) @(negedge clk);
    chk("R7 paused", {stopped, 8'(widx - w0)}, {1'b1, 8'd0});
    resume = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 still paused while high", stopped, 1);
    resume = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 resumed", stopped, 0);
    stop_en = 1'b0;
    while (!done) @(negedge clk);
    chk("R8 no pause, one miss per pass", {err_cnt, stopped}, {8'd4, 1'b0});

    // Run 3: whole page bad, error counter wraps
    f_lo = 10'h100; f_hi = 10'h1FF;
    do_reset();
    while (!done) @(negedge clk);
    chk("R6 wrap after 1024 misses", {err_cnt, err_seen}, {8'd0, 1'b1});
    disp_sel = 1'b0; #1;
    chk("R9 wrapped error view", disp, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule